// File: doc/BRIEF.md
# Guest-Level Trap Routing and Handler Vectoring

This unit sits at the trap-entry point of a hart that supports guest virtualization. For each trap it receives the cause, the faulting PC, the trap value, the current privilege level and virtualization flag, and the four delegation masks. From these it decides which level takes the trap: the guest supervisor (VS), the host supervisor (HS) or machine mode (M).

When the guest supervisor takes the trap, the unit does three things. It computes the handler address from the guest trap-vector register, which can be in direct or vectored mode. It produces the values to write into the guest cause, EPC and trap-value registers. It also converts guest interrupt numbers to the matching supervisor numbers, so that guest software sees ordinary supervisor interrupts. For HS and M it only raises a one-cycle routing flag. The status register update and the privilege switch for those levels happen elsewhere.

The trap input is a single-cycle `trap_valid` pulse, and the unit accepts one trap on every cycle. It applies no back-pressure, so it has no ready signal. Every output is registered and appears one cycle after the pulse.

Top module: `vtrap_entry`

## Requirements
- R1: Bit XLEN-1 of `trap_cause` marks an interrupt. The cause number is `trap_cause` with that bit cleared. On a guest-level write, bit XLEN-1 of `vs_cause_wdata` equals bit XLEN-1 of `trap_cause`.
- R2: A trap goes to the guest level only when all of the following hold:
  - `cur_virt` is 1.
  - `cur_priv` is U (2'b00) or S (2'b01).
  - The cause number is below XLEN.
  - The bit selected by the cause number is set in `hideleg` (for interrupts) or in `hedeleg` (for exceptions).
- R3: A trap that does not go to the guest level raises `to_hs` when `cur_priv` is U or S, the cause number is below XLEN, and the bit it selects is set in `mideleg` (for interrupts) or in `medeleg` (for exceptions). In every other case it raises `to_m`. In both cases no guest write strobe is raised.
- R4: For a guest-level interrupt, `vs_cause_wdata` is (cause number − 1) with bit XLEN-1 set; for example, 10 becomes 9 and 2 becomes 1. For a guest-level exception, `vs_cause_wdata` is the unchanged cause number.
- R5: When bit 0 of `vstvec` is 1 and the trap is a guest-level interrupt, `pc_wdata` is `vstvec` with bit 0 cleared, plus 4 × the adjusted cause from R4.
- R6: When bit 0 of `vstvec` is 0, or the trap is an exception, `pc_wdata` is `vstvec` with bit 0 cleared.
- R7: On a guest-level trap, `vs_epc_wdata` equals `trap_epc` and `vs_tval_wdata` equals `trap_tval`.
- R8: Each output strobe (`pc_we`, `vs_cause_we`, `vs_epc_we`, `vs_tval_we`, `to_hs`, `to_m`) is high only in the cycle right after a cycle with `trap_valid` high. Each valid trap raises exactly one of three outcomes: the four guest strobes together, `to_hs`, or `to_m`.
- R9: While `rst_n` is low, and until the first trap, every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | One-cycle pulse marking a trap |
| trap_cause | input | XLEN | Cause value; bit XLEN-1 is the interrupt flag |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| cur_priv | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| cur_virt | input | 1 | Hart is running a guest |
| hideleg | input | XLEN | Interrupt delegation mask to the guest level |
| hedeleg | input | XLEN | Exception delegation mask to the guest level |
| mideleg | input | XLEN | Interrupt delegation mask to HS |
| medeleg | input | XLEN | Exception delegation mask to HS |
| vstvec | input | XLEN | Guest trap vector; bit 0 selects vectored mode |
| pc_we | output | 1 | New-PC strobe for a guest-level trap |
| pc_wdata | output | XLEN | Guest handler address |
| vs_cause_we | output | 1 | Guest cause write strobe |
| vs_cause_wdata | output | XLEN | Guest cause value |
| vs_epc_we | output | 1 | Guest EPC write strobe |
| vs_epc_wdata | output | XLEN | Guest EPC value |
| vs_tval_we | output | 1 | Guest trap-value write strobe |
| vs_tval_wdata | output | XLEN | Guest trap value |
| to_hs | output | 1 | Trap is routed to HS |
| to_m | output | 1 | Trap is routed to M |

## Verification
The main corner is a vectored guest external interrupt (cause 10). A design that vectors on the raw cause would jump to base + 40 instead of base + 36. The same test shows whether the recorded cause was lowered to 9 while the interrupt flag was kept.

A guest exception in vectored mode must neither be offset nor decremented. A design that applies the interrupt adjustments to exceptions would record cause 1 instead of 2 and land 4 bytes past the base.

Routing is tested with an interrupt that is not delegated to the guest but is delegated to HS, with a trap taken in M mode while every mask is all ones, and with a non-virtualized trap whose guest bit is set. A design that ignores privilege or `cur_virt` would raise the guest strobes in these cases. A cause number of 64 with full masks catches a design that indexes the mask modulo XLEN.

// File: rtl/vtrap_pkg.sv
package vtrap_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    ROUTE_VS = 2'd0,
    ROUTE_HS = 2'd1,
    ROUTE_M  = 2'd2
  } route_e;

endpackage

// File: rtl/vtrap_route.sv
module vtrap_route
  import vtrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cause,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic [XLEN-1:0] hideleg,
  input  logic [XLEN-1:0] hedeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [XLEN-1:0] medeleg,
  output route_e          route,
  output logic            is_irq,
  output logic [XLEN-1:0] cnum
);

  localparam int IDXW = $clog2(XLEN);
  localparam logic [XLEN-1:0] XLEN_V = XLEN'(XLEN);

  logic            low_priv;
  logic            in_range;
  logic [IDXW-1:0] idx;
  logic [XLEN-1:0] guest_mask;
  logic [XLEN-1:0] host_mask;
  logic            guest_hit;
  logic            host_hit;

  always_comb begin
    is_irq   = cause[XLEN-1];
    cnum     = {1'b0, cause[XLEN-2:0]};
    low_priv = (priv == PRIV_U) || (priv == PRIV_S);
    in_range = cnum < XLEN_V;
    idx      = cnum[IDXW-1:0];

    guest_mask = '0;
    if (virt && low_priv) guest_mask = is_irq ? hideleg : hedeleg;

    host_mask = '0;
    if (low_priv) host_mask = is_irq ? mideleg : medeleg;

    guest_hit = low_priv && in_range && guest_mask[idx];
    host_hit  = low_priv && in_range && host_mask[idx];

    if (guest_hit)     route = ROUTE_VS;
    else if (host_hit) route = ROUTE_HS;
    else               route = ROUTE_M;
  end

endmodule

// File: rtl/vtrap_vector.sv
module vtrap_vector #(
  parameter int XLEN = 64
) (
  input  logic            is_irq,
  input  logic [XLEN-1:0] cnum,
  input  logic [XLEN-1:0] vstvec,
  output logic [XLEN-1:0] cause_val,
  output logic [XLEN-1:0] pc_val
);

  localparam logic [XLEN-1:0] FLAG = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN-1:0] adj;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    // guest interrupt numbers sit one above their supervisor counterparts
    adj       = is_irq ? (cnum - XLEN'(1)) : cnum;
    cause_val = is_irq ? (adj | FLAG) : adj;
    base      = {vstvec[XLEN-1:1], 1'b0};
    offset    = (vstvec[0] && is_irq) ? {adj[XLEN-3:0], 2'b00} : '0;
    pc_val    = base + offset;
  end

endmodule

// File: rtl/vtrap_entry.sv
module vtrap_entry
  import vtrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic [XLEN-1:0] trap_tval,
  input  logic [1:0]      cur_priv,
  input  logic            cur_virt,
  input  logic [XLEN-1:0] hideleg,
  input  logic [XLEN-1:0] hedeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] vstvec,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_wdata,
  output logic            vs_cause_we,
  output logic [XLEN-1:0] vs_cause_wdata,
  output logic            vs_epc_we,
  output logic [XLEN-1:0] vs_epc_wdata,
  output logic            vs_tval_we,
  output logic [XLEN-1:0] vs_tval_wdata,
  output logic            to_hs,
  output logic            to_m
);

  route_e          route;
  logic            is_irq;
  logic [XLEN-1:0] cnum;
  logic [XLEN-1:0] cause_val;
  logic [XLEN-1:0] pc_val;
  logic            take_vs;

  vtrap_route #(.XLEN(XLEN)) u_route (
    .cause   (trap_cause),
    .priv    (cur_priv),
    .virt    (cur_virt),
    .hideleg (hideleg),
    .hedeleg (hedeleg),
    .mideleg (mideleg),
    .medeleg (medeleg),
    .route   (route),
    .is_irq  (is_irq),
    .cnum    (cnum)
  );

  vtrap_vector #(.XLEN(XLEN)) u_vector (
    .is_irq    (is_irq),
    .cnum      (cnum),
    .vstvec    (vstvec),
    .cause_val (cause_val),
    .pc_val    (pc_val)
  );

  assign take_vs = trap_valid && (route == ROUTE_VS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_we          <= 1'b0;
      vs_cause_we    <= 1'b0;
      vs_epc_we      <= 1'b0;
      vs_tval_we     <= 1'b0;
      to_hs          <= 1'b0;
      to_m           <= 1'b0;
      pc_wdata       <= '0;
      vs_cause_wdata <= '0;
      vs_epc_wdata   <= '0;
      vs_tval_wdata  <= '0;
    end else begin
      pc_we       <= take_vs;
      vs_cause_we <= take_vs;
      vs_epc_we   <= take_vs;
      vs_tval_we  <= take_vs;
      to_hs       <= trap_valid && (route == ROUTE_HS);
      to_m        <= trap_valid && (route == ROUTE_M);
      if (take_vs) begin
        pc_wdata       <= pc_val;
        vs_cause_wdata <= cause_val;
        vs_epc_wdata   <= trap_epc;
        vs_tval_wdata  <= trap_tval;
      end
    end
  end

endmodule

// File: rtl/vtrap_entry_chk.sv
module vtrap_entry_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_valid,
  input logic [XLEN-1:0] trap_cause,
  input logic [XLEN-1:0] trap_epc,
  input logic [1:0]      cur_priv,
  input logic [XLEN-1:0] vstvec,
  input logic            pc_we,
  input logic [XLEN-1:0] pc_wdata,
  input logic            vs_cause_we,
  input logic [XLEN-1:0] vs_cause_wdata,
  input logic            vs_epc_we,
  input logic [XLEN-1:0] vs_epc_wdata,
  input logic            vs_tval_we,
  input logic            to_hs,
  input logic            to_m
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_we, to_hs, to_m})); // R8

  AST_GUEST_STROBES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we == vs_cause_we) && (pc_we == vs_epc_we) && (pc_we == vs_tval_we)); // R8

  AST_VALID_GIVES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (pc_we || to_hs || to_m)); // R8

  AST_NO_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !(pc_we || to_hs || to_m)); // R8

  AST_M_PRIV_NOT_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == 2'b11) |=> (to_m && !pc_we)); // R3

  AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (!vs_cause_we || (vs_cause_wdata[XLEN-1] == $past(trap_cause[XLEN-1])))); // R1

  AST_EPC_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (!vs_epc_we || (vs_epc_wdata == $past(trap_epc)))); // R7

  AST_DIRECT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !vstvec[0]) |=> (!pc_we || (pc_wdata == {$past(vstvec[XLEN-1:1]), 1'b0}))); // R6

endmodule

bind vtrap_entry vtrap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .trap_valid     (trap_valid),
  .trap_cause     (trap_cause),
  .trap_epc       (trap_epc),
  .cur_priv       (cur_priv),
  .vstvec         (vstvec),
  .pc_we          (pc_we),
  .pc_wdata       (pc_wdata),
  .vs_cause_we    (vs_cause_we),
  .vs_cause_wdata (vs_cause_wdata),
  .vs_epc_we      (vs_epc_we),
  .vs_epc_wdata   (vs_epc_wdata),
  .vs_tval_we     (vs_tval_we),
  .to_hs          (to_hs),
  .to_m           (to_m)
);

// File: tb/test_vtrap_entry.sv
module test_vtrap_entry;

  localparam int XLEN = 64;
  localparam logic [63:0] INT = 64'h8000_0000_0000_0000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_valid = 1'b0;
  logic [XLEN-1:0] trap_cause = '0;
  logic [XLEN-1:0] trap_epc = '0;
  logic [XLEN-1:0] trap_tval = '0;
  logic [1:0]      cur_priv = 2'b01;
  logic            cur_virt = 1'b0;
  logic [XLEN-1:0] hideleg = '0;
  logic [XLEN-1:0] hedeleg = '0;
  logic [XLEN-1:0] mideleg = '0;
  logic [XLEN-1:0] medeleg = '0;
  logic [XLEN-1:0] vstvec = '0;
  logic            pc_we, vs_cause_we, vs_epc_we, vs_tval_we, to_hs, to_m;
  logic [XLEN-1:0] pc_wdata, vs_cause_wdata, vs_epc_wdata, vs_tval_wdata;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  vtrap_entry #(.XLEN(XLEN)) i_vtrap_entry (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_epc(trap_epc), .trap_tval(trap_tval), .cur_priv(cur_priv), .cur_virt(cur_virt),
    .hideleg(hideleg), .hedeleg(hedeleg), .mideleg(mideleg), .medeleg(medeleg),
    .vstvec(vstvec), .pc_we(pc_we), .pc_wdata(pc_wdata), .vs_cause_we(vs_cause_we),
    .vs_cause_wdata(vs_cause_wdata), .vs_epc_we(vs_epc_we), .vs_epc_wdata(vs_epc_wdata),
    .vs_tval_we(vs_tval_we), .vs_tval_wdata(vs_tval_wdata), .to_hs(to_hs), .to_m(to_m)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outcome as {guest strobes, to_hs, to_m}
  function automatic logic [63:0] outcome();
    return {61'd0, (pc_we & vs_cause_we & vs_epc_we & vs_tval_we), to_hs, to_m};
  endfunction

  // drive at falling edge, captured at next rising edge, sampled at following falling edge
  task automatic fire(input logic [63:0] cause, input logic [1:0] priv, input logic virt);
    @(negedge clk);
    trap_cause = cause; cur_priv = priv; cur_virt = virt;
    trap_epc = 64'h0000_0040_1000_0000 ^ cause; trap_tval = 64'h0bad_cafe_0000_0000 ^ cause;
    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 strobes in reset", outcome(), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 strobes after reset", outcome(), 64'd0);
  endtask

  task automatic t_vec_external();
    hideleg = 64'h400; vstvec = 64'h8000_1001;
    fire(INT | 64'd10, 2'b01, 1'b1);
    chk("R2 guest route ext irq", outcome(), 64'd4);
    chk("R4 R1 ext irq cause 10->9", vs_cause_wdata, INT | 64'd9);
    chk("R5 vectored pc base+36", pc_wdata, 64'h8000_1024);
    chk("R7 epc", vs_epc_wdata, 64'h0000_0040_1000_0000 ^ (INT | 64'd10));
    chk("R7 tval", vs_tval_wdata, 64'h0bad_cafe_0000_0000 ^ (INT | 64'd10));
    @(negedge clk);
    chk("R8 strobes drop after one cycle", outcome(), 64'd0);
  endtask

  task automatic t_vec_soft_user();
    hideleg = 64'h4; vstvec = 64'h0000_2001;
    fire(INT | 64'd2, 2'b00, 1'b1);
    chk("R4 soft irq cause 2->1", vs_cause_wdata, INT | 64'd1);
    chk("R5 vectored pc base+4", pc_wdata, 64'h0000_2004);
  endtask

  task automatic t_direct();
    hideleg = 64'h400; vstvec = 64'h8000_2000;
    fire(INT | 64'd10, 2'b01, 1'b1);
    chk("R6 direct mode pc", pc_wdata, 64'h8000_2000);
    chk("R4 direct mode cause", vs_cause_wdata, INT | 64'd9);
  endtask

  task automatic t_exception();
    hedeleg = 64'h4; hideleg = 64'h0; vstvec = 64'h0000_3001;
    fire(64'd2, 2'b01, 1'b1);
    chk("R2 guest route exception", outcome(), 64'd4);
    chk("R4 exception cause unchanged", vs_cause_wdata, 64'd2);
    chk("R6 exception pc not offset", pc_wdata, 64'h0000_3000);
    chk("R1 exception flag clear", {63'd0, vs_cause_wdata[63]}, 64'd0);
  endtask

  task automatic t_to_hs();
    hideleg = 64'h0; mideleg = 64'h400;
    fire(INT | 64'd10, 2'b01, 1'b1);
    chk("R3 undelegated irq goes to HS", outcome(), 64'd2);
  endtask

  task automatic t_m_priv();
    hideleg = '1; hedeleg = '1; mideleg = '1; medeleg = '1;
    fire(INT | 64'd10, 2'b11, 1'b1);
    chk("R3 M priv goes to M", outcome(), 64'd1);
  endtask

  task automatic t_not_virt();
    hideleg = 64'h400; mideleg = 64'h0;
    fire(INT | 64'd10, 2'b01, 1'b0);
    chk("R2 not virtualized no guest", outcome(), 64'd1);
  endtask

  task automatic t_out_of_range();
    hedeleg = '1; medeleg = '1;
    fire(64'd64, 2'b01, 1'b1);
    chk("R2 cause 64 not delegated", outcome(), 64'd1);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R8: watchdog expired, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_vec_external();
    t_vec_soft_user();
    t_direct();
    t_exception();
    t_to_hs();
    t_m_priv();
    t_not_virt();
    t_out_of_range();
    @(negedge clk);
    chk("R8 idle no strobes", outcome(), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule